// File: doc/BRIEF.md
# Period-Match Timer with Protected Edge Capture

This block is a 16-bit up-counter with two capture channels, controlled over a byte-wide register bus. The counter advances on one of two tick sources: a quarter-rate tick taken from the system clock, or rising edges on an external count pin. It advances only while the run bit is set. In period mode, the first 16-bit register holds a period. When the counter reaches that value it restarts at zero and raises a sticky timer flag.

The second channel watches an asynchronous capture pin. The pin passes through a two-flop synchronizer and an edge detector. A free-running 4-bit event prescaler then turns the pin activity into capture events. On an event, the channel copies the counter into the second capture register, as long as the previous value has been read out. If that value is still unread, the copy is suppressed and a hidden pending-overflow bit is set instead. That bit reaches the visible overflow status only after software has read both capture bytes.

In capture mode, the first register stops acting as the period. It latches the counter on every capture event, and the counter then runs through the full 16-bit range. Each of the three flags has its own enable bit, and each drives one interrupt request line.

Top module: `cap_timer`

## Requirements
- R1: The counter advances by one for each tick while CTRL bit0 (run) is 1, and holds while run is 0. The tick source is chosen by CTRL bit1. With bit1 = 0 the tick occurs once every 4 system clocks, so any 400 consecutive clocks give exactly 100 ticks. With bit1 = 1 the tick is each synchronized rising edge of `tclk_pin`.
- R2: With CTRL bit2 = 0 (period mode), a tick taken while the counter equals the period register (address 1 = low byte, address 2 = high byte) loads 0 and sets STAT bit0. With period P, K ticks from zero leave the counter at K mod (P+1), and STAT bit0 is set exactly when K > P.
- R3: With CTRL bit2 = 1 (capture mode), each capture event copies the counter into addresses 1/2 and sets STAT bit1. In this mode the counter wraps from FFFFh to 0 and sets STAT bit0, whatever the period register holds. In period mode, STAT bit1 is never set.
- R4: CTRL bits 4:3 select the capture event. 00 fires on every falling edge, 01 on every rising edge, 10 on every 4th rising edge and 11 on every 16th rising edge of the synchronized `cap_pin`.
- R5: The event prescaler counts every rising edge from reset, whatever edge select is in force. Changing the select never clears it, so the nth rising edge since reset is a divide-by-4 event when n is a multiple of 4 and a divide-by-16 event when n is a multiple of 16.
- R6: A capture event with no unread value copies the counter into the capture register (address 3 = low byte, address 4 = high byte) and sets STAT bit2. The pin passes two synchronizer flops before the edge detector.
- R7: A capture event that arrives while the previous capture is unread leaves the capture register unchanged and sets the hidden pending-overflow bit.
- R8: Once both capture bytes have been read, in either order, the pending-overflow bit is copied to STAT bit3, cleared, and the capture register is open again. Reading only one byte changes nothing.
- R9: STAT bits 0 to 2 stay set until a write to STAT with a 1 in that bit position clears them. A hardware set in the same cycle wins over the clear.
- R10: `irq_tmr`, `irq_cap1` and `irq_cap2` are STAT bits 0, 1 and 2, each ANDed with IEN (address 6) bits 0, 1 and 2 respectively.
- R11: After reset, CTRL, IEN, STAT, both capture registers and the counter read 0, and the period register reads FFFFh. Writes to address 7 (low byte) and address 8 (high byte) load the counter, taking priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; marks capture bytes as read |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tclk_pin | input | 1 | External count clock, asynchronous |
| cap_pin | input | 1 | Capture input, asynchronous |
| irq_tmr | output | 1 | Timer interrupt request |
| irq_cap1 | output | 1 | First-channel capture interrupt request |
| irq_cap2 | output | 1 | Second-channel capture interrupt request |

## Verification
The bound assertions check five behaviours on every cycle:
- a blocked event never alters the stored capture and always sets the pending-overflow bit;
- a period match wraps the counter and raises the timer flag;
- the first-channel flag never rises in period mode, and flags stay sticky until cleared;
- a masked request stays low;
- edge pulses last one cycle.

Other behaviours need the bench's scenarios, because they depend on history:
- the counts reached over a sweep of periods and tick totals;
- the choice of edge under each select;
- the prescaler phase carried across select changes;
- the one-byte versus two-byte read rule for promoting the overflow status.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = 16;
  localparam int ADDR_W  = 4;
  localparam int PRESC_W = 4;

  typedef enum logic [1:0] {
    EDGE_FALL   = 2'b00,
    EDGE_RISE   = 2'b01,
    EDGE_RISE4  = 2'b10,
    EDGE_RISE16 = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_REG1_L = 4'd1;
  localparam logic [ADDR_W-1:0] A_REG1_H = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAP2_L = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP2_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd8;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       cap1_mode;
    logic       ext_sel;
    logic       run;
  } ctrl_t;

  // Counter step: restart at zero on reaching the limit.
  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] limit);
    if (cnt == limit) return '0;
    return cnt + 1'b1;
  endfunction

  // Capture event decision from the edge pulses and the prescaler state
  // before the current rising edge is counted.
  function automatic logic event_hit(input edge_sel_e sel, input logic rise,
                                     input logic fall, input logic [PRESC_W-1:0] pc);
    case (sel)
      EDGE_FALL:   return fall;
      EDGE_RISE:   return rise;
      EDGE_RISE4:  return rise && (pc[1:0] == 2'b11);
      default:     return rise && (pc == {PRESC_W{1'b1}});
    endcase
  endfunction
endpackage

// File: rtl/ct_sync_edge.sv
`timescale 1ns/1ps
module ct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      prev  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], pin};
      prev  <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/ct_event_sel.sv
`timescale 1ns/1ps
module ct_event_sel
  import ct_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rise,
  input  logic      fall,
  input  edge_sel_e sel,
  output logic      evt
);
  logic [PRESC_W-1:0] pcount;

  // Counts every rising edge; only reset clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcount <= '0;
    else if (rise) pcount <= pcount + 1'b1;
  end

  assign evt = event_hit(sel, rise, fall, pcount);
endmodule

// File: rtl/ct_timer.sv
`timescale 1ns/1ps
module ct_timer
  import ct_pkg::*;
#(
  parameter int W     = CNT_W,
  parameter int DIV_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ext_sel,
  input  logic          ext_rise,
  input  logic          use_period,
  input  logic [W-1:0]  period,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DATA_W-1:0] ld_byte,
  output logic [W-1:0]  count,
  output logic          tick,
  output logic          wrap
);
  logic [DIV_W-1:0] div;
  logic [W-1:0]     limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;
  end

  assign tick  = run & (ext_sel ? ext_rise : (&div));
  assign limit = use_period ? period : {W{1'b1}};
  assign wrap  = tick & (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) count[DATA_W-1:0] <= ld_byte;
      if (ld_hi) count[W-1:DATA_W] <= ld_byte;
    end else if (tick) begin
      count <= count_next(count, limit);
    end
  end
endmodule

// File: rtl/cap_timer.sv
`timescale 1ns/1ps
module cap_timer
  import ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tclk_pin,
  input  logic              cap_pin,
  output logic              irq_tmr,
  output logic              irq_cap1,
  output logic              irq_cap2
);
  localparam int NPIN = 2;
  localparam int NIRQ = 3;

  ctrl_t             ctrl_q;
  logic [NIRQ-1:0]   ien_q;
  logic              tmr_flag, cap1_flag, cap2_flag;
  logic              ovf_master, ovf_slave;
  logic [CNT_W-1:0]  reg1_q, cap2_q, count;
  logic              unread, seen_lo, seen_hi;

  // Pin conditioning: index 0 = capture pin, index 1 = count clock pin.
  logic [NPIN-1:0] pins, pin_lvl, pin_rise, pin_fall;
  assign pins = {tclk_pin, cap_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pins[g]),
      .level(pin_lvl[g]), .rise(pin_rise[g]), .fall(pin_fall[g])
    );
  end

  logic cap_rise;
  assign cap_rise = pin_rise[0];

  // Bus decode
  logic wr_ctrl, wr_r1l, wr_r1h, wr_stat, wr_ien, wr_cl, wr_ch, load_any;
  logic rd_lo_now, rd_hi_now;
  assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  assign wr_r1l   = bus_wr && (bus_addr == A_REG1_L);
  assign wr_r1h   = bus_wr && (bus_addr == A_REG1_H);
  assign wr_stat  = bus_wr && (bus_addr == A_STAT);
  assign wr_ien   = bus_wr && (bus_addr == A_IEN);
  assign wr_cl    = bus_wr && (bus_addr == A_CNT_L);
  assign wr_ch    = bus_wr && (bus_addr == A_CNT_H);
  assign load_any = wr_cl | wr_ch;
  assign rd_lo_now = bus_rd && (bus_addr == A_CAP2_L);
  assign rd_hi_now = bus_rd && (bus_addr == A_CAP2_H);

  logic clr_tmr, clr_cap1, clr_cap2;
  assign clr_tmr  = wr_stat & bus_wdata[0];
  assign clr_cap1 = wr_stat & bus_wdata[1];
  assign clr_cap2 = wr_stat & bus_wdata[2];

  // Counter
  logic tmr_tick, tmr_wrap;
  ct_timer #(.W(CNT_W), .DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .ext_sel(ctrl_q.ext_sel),
    .ext_rise(pin_rise[1]), .use_period(~ctrl_q.cap1_mode), .period(reg1_q),
    .ld_lo(wr_cl), .ld_hi(wr_ch), .ld_byte(bus_wdata),
    .count(count), .tick(tmr_tick), .wrap(tmr_wrap)
  );

  // Capture event
  logic cap_event;
  ct_event_sel u_evt (
    .clk(clk), .rst_n(rst_n), .rise(cap_rise), .fall(pin_fall[0]),
    .sel(edge_sel_e'(ctrl_q.edge_sel)), .evt(cap_event)
  );

  // Capture channel 2 protection
  logic promote, cap_take, cap_blocked, cap1_take;
  assign promote     = unread & (seen_lo | rd_lo_now) & (seen_hi | rd_hi_now);
  assign cap_take    = cap_event & (~unread | promote);
  assign cap_blocked = cap_event & unread & ~promote;
  assign cap1_take   = cap_event & ctrl_q.cap1_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap2_q     <= '0;
      unread     <= 1'b0;
      seen_lo    <= 1'b0;
      seen_hi    <= 1'b0;
      ovf_master <= 1'b0;
      ovf_slave  <= 1'b0;
    end else begin
      if (promote) begin
        ovf_slave  <= ovf_master;
        ovf_master <= 1'b0;
        unread     <= 1'b0;
        seen_lo    <= 1'b0;
        seen_hi    <= 1'b0;
      end else if (unread) begin
        seen_lo <= seen_lo | rd_lo_now;
        seen_hi <= seen_hi | rd_hi_now;
      end
      if (cap_take) begin
        cap2_q <= count;
        unread <= 1'b1;
      end
      if (cap_blocked) ovf_master <= 1'b1;
    end
  end

  // Control, enable, first register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      reg1_q <= {CNT_W{1'b1}};
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[4:0]);
      if (wr_ien)  ien_q  <= bus_wdata[NIRQ-1:0];
      if (cap1_take) begin
        reg1_q <= count;
      end else begin
        if (wr_r1l) reg1_q[DATA_W-1:0]     <= bus_wdata;
        if (wr_r1h) reg1_q[CNT_W-1:DATA_W] <= bus_wdata;
      end
    end
  end

  // Sticky flags: hardware set wins over software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_flag  <= 1'b0;
      cap1_flag <= 1'b0;
      cap2_flag <= 1'b0;
    end else begin
      if (tmr_wrap)      tmr_flag <= 1'b1;
      else if (clr_tmr)  tmr_flag <= 1'b0;
      if (cap1_take)     cap1_flag <= 1'b1;
      else if (clr_cap1) cap1_flag <= 1'b0;
      if (cap_take)      cap2_flag <= 1'b1;
      else if (clr_cap2) cap2_flag <= 1'b0;
    end
  end

  assign irq_tmr  = tmr_flag  & ien_q[0];
  assign irq_cap1 = cap1_flag & ien_q[1];
  assign irq_cap2 = cap2_flag & ien_q[2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {3'b000, ctrl_q};
      A_REG1_L: bus_rdata = reg1_q[DATA_W-1:0];
      A_REG1_H: bus_rdata = reg1_q[CNT_W-1:DATA_W];
      A_CAP2_L: bus_rdata = cap2_q[DATA_W-1:0];
      A_CAP2_H: bus_rdata = cap2_q[CNT_W-1:DATA_W];
      A_STAT:   bus_rdata = {4'b0000, ovf_slave, cap2_flag, cap1_flag, tmr_flag};
      A_IEN:    bus_rdata = {5'b00000, ien_q};
      A_CNT_L:  bus_rdata = count[DATA_W-1:0];
      A_CNT_H:  bus_rdata = count[CNT_W-1:DATA_W];
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ct_checker.sv
`timescale 1ns/1ps
module ct_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cap_blocked,
  input logic        cap_take,
  input logic [15:0] cap2_q,
  input logic        ovf_master,
  input logic        cap1_mode,
  input logic        cap1_flag,
  input logic        cap2_flag,
  input logic        ien2,
  input logic        irq_cap2,
  input logic        tmr_wrap,
  input logic        load_any,
  input logic [15:0] count,
  input logic        tmr_flag,
  input logic        clr_tmr,
  input logic        cap_rise
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cap_blocked |=> $stable(cap2_q)); // R7
  AST_OVF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cap_blocked |=> ovf_master); // R7
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wrap && !load_any) |=> (count == 16'h0000) && tmr_flag); // R2
  AST_CAP1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cap1_mode |=> !$rose(cap1_flag)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ien2 |-> !irq_cap2); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !clr_tmr) |=> tmr_flag); // R9
  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> !cap_rise); // R6
  AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> cap2_flag); // R6
endmodule

bind cap_timer ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cap_blocked(cap_blocked), .cap_take(cap_take),
  .cap2_q(cap2_q), .ovf_master(ovf_master), .cap1_mode(ctrl_q.cap1_mode),
  .cap1_flag(cap1_flag), .cap2_flag(cap2_flag), .ien2(ien_q[2]),
  .irq_cap2(irq_cap2), .tmr_wrap(tmr_wrap), .load_any(load_any),
  .count(count), .tmr_flag(tmr_flag), .clr_tmr(clr_tmr), .cap_rise(cap_rise)
);

// File: tb/cap_timer_tb_top.sv
`timescale 1ns/1ps
module cap_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       tclk_pin = 1'b0, cap_pin = 1'b0;
  logic       irq_tmr, irq_cap1, irq_cap2;

  int errors = 0;
  int checks = 0;
  int rises  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cap_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tclk_pin(tclk_pin), .cap_pin(cap_pin),
    .irq_tmr(irq_tmr), .irq_cap1(irq_cap1), .irq_cap2(irq_cap2)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] lo, input logic [3:0] hi, output logic [15:0] v);
    logic [7:0] b;
    rd(lo, b); v[7:0] = b;
    rd(hi, b); v[15:8] = b;
  endtask

  task automatic load_cnt(input logic [15:0] v);
    wr(4'd7, v[7:0]);
    wr(4'd8, v[15:8]);
  endtask

  task automatic tpulse();
    @(negedge clk) tclk_pin = 1'b1;
    repeat (4) @(negedge clk);
    tclk_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cset(input logic v);
    @(negedge clk);
    if (v && !cap_pin) rises++;
    cap_pin = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  b, b0;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    rd(4'd0, b); check("R11 ctrl", b, 0);
    rd16(4'd1, 4'd2, v); check("R11 period", v, 16'hFFFF);
    rd16(4'd3, 4'd4, v); check("R11 cap2", v, 0);
    rd(4'd5, b); check("R11 stat", b, 0);
    rd(4'd6, b); check("R11 ien", b, 0);
    rd16(4'd7, 4'd8, v); check("R11 count", v, 0);
    check("R10 irqs reset", {irq_tmr, irq_cap1, irq_cap2}, 0);

    // R1 internal quarter-rate tick
    wr(4'd0, 8'h01);
    @(negedge clk); bus_addr = 4'd7; #2 b0 = bus_rdata;
    repeat (400) @(negedge clk);
    #2 b = bus_rdata;
    check("R1 quarter rate", 8'(b - b0), 100);
    wr(4'd0, 8'h00);
    @(negedge clk); bus_addr = 4'd7; #2 b0 = bus_rdata;
    repeat (40) @(negedge clk);
    #2 check("R1 hold when stopped", bus_rdata, b0);
    // R1 external pin ignored while stopped
    wr(4'd0, 8'h02);
    load_cnt(16'h0010);
    tpulse(); tpulse(); tpulse();
    rd16(4'd7, 4'd8, v); check("R1 ext stopped", v, 16'h0010);

    // R2 period sweep with external ticks
    wr(4'd0, 8'h03);
    for (int p = 0; p < 5; p++) begin
      wr(4'd1, 8'(p)); wr(4'd2, 8'h00);
      for (int k = 0; k < 8; k++) begin
        load_cnt(16'h0000);
        wr(4'd5, 8'h01);
        for (int t = 0; t < k; t++) tpulse();
        rd16(4'd7, 4'd8, v); check("R2 count", v, k % (p + 1));
        rd(4'd5, b); check("R2 flag", b[0], (k > p) ? 1 : 0);
      end
    end
    // R9 sticky then W1C, R10 masking
    tpulse(); tpulse(); tpulse(); tpulse(); tpulse();
    repeat (20) @(negedge clk);
    rd(4'd5, b); check("R9 sticky", b[0], 1);
    check("R10 tmr masked", irq_tmr, 0);
    wr(4'd6, 8'h01); #2 check("R10 tmr enabled", irq_tmr, 1);
    wr(4'd5, 8'h01); rd(4'd5, b); check("R9 cleared", b[0], 0);
    check("R10 tmr follows flag", irq_tmr, 0);

    // R6/R7/R8 capture with protection, rising-edge select
    wr(4'd0, 8'h08);
    load_cnt(16'h1234);
    cset(1'b1);
    rd(4'd5, b); check("R6 cap2 flag", b[2], 1);
    check("R3 cap1 flag silent", b[1], 0);
    check("R10 cap2 masked", irq_cap2, 0);
    wr(4'd6, 8'h04); #2 check("R10 cap2 enabled", irq_cap2, 1);
    cset(1'b0);
    load_cnt(16'h5678);
    cset(1'b1);
    rd(4'd5, b); check("R8 ovf not yet", b[3], 0);
    rd(4'd3, b); check("R7 kept low", b, 8'h34);
    rd(4'd5, b); check("R8 one byte no promote", b[3], 0);
    rd(4'd4, b); check("R7 kept high", b, 8'h12);
    rd(4'd5, b); check("R8 ovf promoted", b[3], 1);
    check("R9 cap2 sticky", b[2], 1);
    wr(4'd5, 8'h04); rd(4'd5, b); check("R9 cap2 cleared", b[2], 0);
    cset(1'b0);
    load_cnt(16'h9ABC);
    cset(1'b1);
    rd(4'd4, b); check("R8 high first", b, 8'h9A);
    rd(4'd3, b); check("R8 low second", b, 8'hBC);
    rd(4'd5, b); check("R8 ovf cleared", b[3], 0);
    wr(4'd5, 8'h04);
    cset(1'b0);
    wr(4'd6, 8'h00);

    // R4/R5 edge-select sweep, prescaler phase carried across changes
    for (int s = 0; s < 4; s++) begin
      wr(4'd0, 8'(s << 3));
      for (int i = 0; i < 10; i++) begin
        for (int e = 1; e >= 0; e--) begin
          bit ex;
          logic [15:0] val;
          val = 16'((s * 16 + i) * 256 + e);
          load_cnt(val);
          cset(e[0]);
          if (e == 1)
            ex = (s == 1) || (s == 2 && rises % 4 == 0) || (s == 3 && rises % 16 == 0);
          else
            ex = (s == 0);
          rd(4'd5, b);
          check((s >= 2) ? "R5 prescaled event" : "R4 edge event", b[2], ex);
          check("R3 no cap1 in period mode", b[1], 0);
          if (ex) begin
            rd16(4'd3, 4'd4, v); check("R4 captured value", v, val);
            wr(4'd5, 8'h04);
          end
        end
      end
    end

    // R3 capture mode
    wr(4'd0, 8'h0C);
    load_cnt(16'h00AB);
    cset(1'b1);
    rd16(4'd1, 4'd2, v); check("R3 reg1 captured", v, 16'h00AB);
    rd(4'd5, b); check("R3 cap1 flag", b[1], 1);
    wr(4'd6, 8'h02); #2 check("R10 cap1 enabled", irq_cap1, 1);
    cset(1'b0);
    wr(4'd5, 8'h07);
    wr(4'd0, 8'h07);
    load_cnt(16'hFFFE);
    tpulse();
    rd(4'd5, b); check("R3 no wrap at FFFF-1", b[0], 0);
    tpulse();
    rd16(4'd7, 4'd8, v); check("R3 full-range wrap", v, 0);
    rd(4'd5, b); check("R3 wrap flag", b[0], 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule